// File: doc/BRIEF.md
# Time-Shared Second-Order Recursive Filter

This block computes a second-order recursive (IIR) filter on a stream of signed 16-bit samples. Only one constant-coefficient multiplier and one saturating adder do the arithmetic. A controller reuses them across a fixed six-cycle sample period. The multiplier is a two-stage pipeline and the adder is a single registered stage. The last two additions of each sample therefore spill into the first two cycles of the following period, and consecutive sample periods overlap. Three stores hold intermediate values: two single-entry holding registers written from the multiplier, and a two-tap delay line holding the previous two state values. The adder's registered output also feeds back into its own second operand, so it acts as an accumulator.

A sample is offered by raising `start` for one cycle with the value on `din`. The controller is a state machine with the states PH_IDLE and PH_0 through PH_5. Its transitions are:

- PH_IDLE goes to PH_0 when `start` is high and stays in PH_IDLE otherwise.
- Each PH_k goes to PH_k+1 unconditionally for k from 0 to 4.
- PH_5 goes to PH_0 when `start` is high and to PH_IDLE otherwise.

A separate two-bit tail register marks the two cycles that follow PH_5, in which the output additions run. Each result appears on `dout` together with a one-cycle `out_valid` pulse.

Top module: `iir2_tdm`

## Requirements
- R1: While `rst` is high, and after it is released until a sample has been processed, `out_valid` is 0 and `dout` is 0.
- R2: The state value is w = sat(sat(P(1229, w1) + P(819, w2)) + P(20480, x)), added in that order. The coefficients are Q4.12 codes (5, 0.3, 0.2). w1 and w2 are the state values of the two previous accepted samples, and both start at 0 after reset.
- R3: The output is y = sat(sat(P(1638, w1) + P(2458, w2)) + P(2867, w)), added in that order. The coefficient codes are 0.4, 0.6 and 0.7 in Q4.12, and w1 and w2 are the values held before this sample updates them.
- R4: Each accepted sample produces exactly one `out_valid` pulse, one cycle wide. The pulse is high in the tenth cycle after the cycle in which `start` was presented and accepted. Results emerge in acceptance order.
- R5: A `start` presented while the controller is in PH_0 to PH_4 is ignored: it produces no output and does not alter the state values.
- R6: A `start` presented in PH_5 is accepted, so samples may arrive every 6 cycles indefinitely. The adder's tail operations never collide with the additions of the next period.
- R7: Every adder result saturates to the range -32768 to 32767 instead of wrapping.
- R8: Each product P(c, v) = c·v + 2048, arithmetically shifted right by 12, then clipped to the signed 16-bit range. This rounds to nearest, with ties toward +infinity.
- R9: The delay line keeps its contents during idle gaps of any length between samples.
- R10: `dout` holds the most recent result unchanged between `out_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe offering the sample on `din` |
| din | input | 16 | Signed input sample, sampled only when `start` is accepted |
| out_valid | output | 1 | One-cycle pulse marking a new result on `dout` |
| dout | output | 16 | Signed filter output, held until the next result |

## Verification
An isolated impulse followed by zero samples with idle gaps of varying length shows whether the recursion remembers w1 and w2 across idle time, and whether the feedback and feedforward taps use the right delays. A back-to-back stream at one sample per six cycles exposes any clash between the spilled tail additions and the next period's work. An alternating-sign stream exercises rounding of negative products. Runs of full-scale positive and negative samples drive every accumulation into clipping. Bursts of `start` during PH_0 to PH_4 separate a controller that ignores them from one that restarts or double-counts.

// File: rtl/iir2_pkg.sv
package iir2_pkg;

    // Controller phases: idle plus six schedule steps per sample period
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_0    = 3'd1,
        PH_1    = 3'd2,
        PH_2    = 3'd3,
        PH_3    = 3'd4,
        PH_4    = 3'd5,
        PH_5    = 3'd6
    } phase_e;

    // Multiplier operand source
    typedef enum logic [1:0] {
        MSRC_X   = 2'd0,
        MSRC_W1  = 2'd1,
        MSRC_W2  = 2'd2,
        MSRC_ACC = 2'd3
    } msrc_e;

    // Multiplier coefficient select
    typedef enum logic [2:0] {
        K_IN  = 3'd0,
        K_FB1 = 3'd1,
        K_FB2 = 3'd2,
        K_FF0 = 3'd3,
        K_FF1 = 3'd4,
        K_FF2 = 3'd5
    } ksel_e;

    // Adder first operand source
    typedef enum logic [1:0] {
        ASRC_ST0 = 2'd0,
        ASRC_ST1 = 2'd1,
        ASRC_MUL = 2'd2
    } asrc_e;

    // Adder second operand source
    typedef enum logic {
        BSRC_MUL = 1'b0,
        BSRC_ACC = 1'b1
    } bsrc_e;

    typedef struct packed {
        msrc_e msrc;
        ksel_e ksel;
        logic  add_go;
        asrc_e asrc;
        bsrc_e bsrc;
        logic  st0_we;
        logic  st1_we;
        logic  shift;
        logic  out_load;
    } ctl_t;

    // Number of delay-line taps for a second-order section
    localparam int TAPS = 2;

endpackage

// File: rtl/iir2_seq.sv
module iir2_seq
    import iir2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output ctl_t ctl
);

    phase_e     state_q;
    logic [1:0] tail_q;   // [0]: first cycle after PH_5, [1]: second

    assign accept = start && ((state_q == PH_IDLE) || (state_q == PH_5));

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            tail_q  <= '0;
        end else begin
            tail_q <= {tail_q[0], (state_q == PH_5)};
            unique case (state_q)
                PH_IDLE: if (start) state_q <= PH_0;
                PH_0:    state_q <= PH_1;
                PH_1:    state_q <= PH_2;
                PH_2:    state_q <= PH_3;
                PH_3:    state_q <= PH_4;
                PH_4:    state_q <= PH_5;
                PH_5:    state_q <= start ? PH_0 : PH_IDLE;
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    // Control outputs
    always_comb begin
        ctl = '0;
        unique case (state_q)
            PH_0: begin
                ctl.msrc = MSRC_W1;
                ctl.ksel = K_FB1;
            end
            PH_1: begin
                ctl.msrc = MSRC_W2;
                ctl.ksel = K_FB2;
            end
            PH_2: begin
                ctl.msrc   = MSRC_X;
                ctl.ksel   = K_IN;
                ctl.st0_we = 1'b1;      // capture feedback product 1
            end
            PH_3: begin
                ctl.msrc   = MSRC_W1;
                ctl.ksel   = K_FF1;
                ctl.add_go = 1'b1;      // fb1 + fb2
                ctl.asrc   = ASRC_ST0;
                ctl.bsrc   = BSRC_MUL;
            end
            PH_4: begin
                ctl.msrc   = MSRC_W2;
                ctl.ksel   = K_FF2;
                ctl.add_go = 1'b1;      // + scaled input -> w
                ctl.asrc   = ASRC_MUL;
                ctl.bsrc   = BSRC_ACC;
            end
            PH_5: begin
                ctl.msrc   = MSRC_ACC;
                ctl.ksel   = K_FF0;
                ctl.st1_we = 1'b1;      // capture feedforward product 1
                ctl.shift  = 1'b1;      // w -> delay line
            end
            default: ;
        endcase
        if (tail_q[0]) begin
            ctl.add_go = 1'b1;          // ff1 + ff2
            ctl.asrc   = ASRC_ST1;
            ctl.bsrc   = BSRC_MUL;
        end
        if (tail_q[1]) begin
            ctl.add_go   = 1'b1;        // + ff0 -> y
            ctl.asrc     = ASRC_MUL;
            ctl.bsrc     = BSRC_ACC;
            ctl.out_load = 1'b1;
        end
    end

    // R5: mid-period start never restarts the schedule
    p_ignore_mid_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {PH_0, PH_1, PH_2, PH_3, PH_4}) |=>
            !(state_q inside {PH_IDLE, PH_0}));

    // R6: tail additions never overlap the in-period additions
    p_adder_free_r6: assert property (@(posedge clk) disable iff (rst)
        (tail_q != 2'b00) |-> !(state_q inside {PH_3, PH_4}));

    // R6: start in the last phase chains straight into a new period
    p_chain_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_5 && start) |=> (state_q == PH_0));

endmodule

// File: rtl/iir2_cmul.sv
module iir2_cmul #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] op,
    input  logic signed [CW-1:0] coef,
    output logic signed [DW-1:0] res
);

    localparam int PW = DW + CW;
    localparam int RW = PW + 1;
    localparam logic signed [RW-1:0] HALF = RW'(1) << (FRAC - 1);
    localparam logic signed [RW-1:0] HI   = RW'((2 ** (DW - 1)) - 1);
    localparam logic signed [RW-1:0] LO   = ~HI;

    logic signed [PW-1:0] prod_q;
    logic signed [RW-1:0] rnd;
    logic signed [RW-1:0] shr;
    logic signed [DW-1:0] res_d;
    logic [1:0]           age_q;

    always_comb begin
        rnd = {prod_q[PW-1], prod_q} + HALF;
        shr = rnd >>> FRAC;
        if (shr > HI) begin
            res_d = HI[DW-1:0];
        end else if (shr < LO) begin
            res_d = LO[DW-1:0];
        end else begin
            res_d = shr[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            res    <= '0;
            age_q  <= '0;
        end else begin
            prod_q <= op * coef;
            res    <= res_d;
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    // R8: a zero operand yields a zero product two cycles later
    p_zero_in_r8: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(op, 2) == '0) |-> (res == '0));

endmodule

// File: rtl/iir2_sadd.sv
module iir2_sadd #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] sum_q
);

    logic signed [DW:0]   wide;
    logic signed [DW-1:0] clip;

    always_comb begin
        wide = {a[DW-1], a} + {b[DW-1], b};
        if (wide[DW] != wide[DW-1]) begin
            clip = wide[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        end else begin
            clip = wide[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else if (go) begin
            sum_q <= clip;
        end
    end

    // R7: two non-negative operands never wrap to a negative result
    p_no_wrap_pos_r7: assert property (@(posedge clk) disable iff (rst)
        (go && !a[DW-1] && !b[DW-1]) |=> !sum_q[DW-1]);

    // R7: two negative operands never wrap to a non-negative result
    p_no_wrap_neg_r7: assert property (@(posedge clk) disable iff (rst)
        (go && a[DW-1] && b[DW-1]) |=> sum_q[DW-1]);

endmodule

// File: rtl/iir2_tdm.sv
module iir2_tdm
    import iir2_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int FRAC     = 12,
    parameter int K_IN_C   = 20480,
    parameter int K_FB1_C  = 1229,
    parameter int K_FB2_C  = 819,
    parameter int K_FF0_C  = 2867,
    parameter int K_FF1_C  = 1638,
    parameter int K_FF2_C  = 2458
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [DW-1:0] din,
    output logic                 out_valid,
    output logic signed [DW-1:0] dout
);

    ctl_t                 ctl;
    logic                 accept;
    logic signed [DW-1:0] x_q;
    logic signed [DW-1:0] st0_q;
    logic signed [DW-1:0] st1_q;
    logic signed [DW-1:0] tap_q [TAPS];
    logic signed [DW-1:0] mul_op;
    logic signed [CW-1:0] mul_k;
    logic signed [DW-1:0] mul_res;
    logic signed [DW-1:0] add_a;
    logic signed [DW-1:0] add_b;
    logic signed [DW-1:0] acc;
    logic                 load_q;
    logic [3:0]           age_q;

    iir2_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .ctl    (ctl)
    );

    // Operand and coefficient selection
    always_comb begin
        unique case (ctl.msrc)
            MSRC_X:   mul_op = x_q;
            MSRC_W1:  mul_op = tap_q[0];
            MSRC_W2:  mul_op = tap_q[1];
            MSRC_ACC: mul_op = acc;
            default:  mul_op = '0;
        endcase
        unique case (ctl.ksel)
            K_IN:    mul_k = CW'(K_IN_C);
            K_FB1:   mul_k = CW'(K_FB1_C);
            K_FB2:   mul_k = CW'(K_FB2_C);
            K_FF0:   mul_k = CW'(K_FF0_C);
            K_FF1:   mul_k = CW'(K_FF1_C);
            K_FF2:   mul_k = CW'(K_FF2_C);
            default: mul_k = '0;
        endcase
        unique case (ctl.asrc)
            ASRC_ST0: add_a = st0_q;
            ASRC_ST1: add_a = st1_q;
            default:  add_a = mul_res;
        endcase
        add_b = (ctl.bsrc == BSRC_ACC) ? acc : mul_res;
    end

    iir2_cmul #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .op   (mul_op),
        .coef (mul_k),
        .res  (mul_res)
    );

    iir2_sadd #(.DW(DW)) u_add (
        .clk   (clk),
        .rst   (rst),
        .go    (ctl.add_go),
        .a     (add_a),
        .b     (add_b),
        .sum_q (acc)
    );

    // Stores, delay line and output stage
    always_ff @(posedge clk) begin
        if (rst) begin
            x_q       <= '0;
            st0_q     <= '0;
            st1_q     <= '0;
            for (int i = 0; i < TAPS; i++) tap_q[i] <= '0;
            load_q    <= 1'b0;
            out_valid <= 1'b0;
            dout      <= '0;
            age_q     <= '0;
        end else begin
            if (accept)     x_q   <= din;
            if (ctl.st0_we) st0_q <= mul_res;
            if (ctl.st1_we) st1_q <= mul_res;
            if (ctl.shift) begin
                for (int i = TAPS - 1; i > 0; i--) tap_q[i] <= tap_q[i-1];
                tap_q[0] <= acc;
            end
            load_q    <= ctl.out_load;
            out_valid <= load_q;
            if (load_q) dout <= acc;
            if (age_q != 4'hF) age_q <= age_q + 4'd1;
        end
    end

    // R4: every accepted start yields a result ten cycles later
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 4'd11 && $past(accept, 10)) |-> out_valid);

    // R4: no result without a matching accepted start
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 4'd11 && out_valid) |-> $past(accept, 10));

    // R4: result strobe is one cycle wide
    p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R10: output value held between strobes
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(dout));

    // R9: delay line only moves on the scheduled shift
    p_taps_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !ctl.shift |=> ($stable(tap_q[0]) && $stable(tap_q[1])));

endmodule

// File: tb/iir2_tdm_test.sv
`timescale 1ns/1ps
module iir2_tdm_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic signed [15:0] din = '0;
    logic               out_valid;
    logic signed [15:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int got = 0;
    int sent_cyc = 0;
    int last_valid_cyc = 0;
    logic signed [15:0] last_out = '0;
    logic signed [15:0] mon_exp;
    logic signed [15:0] m_w1 = '0;
    logic signed [15:0] m_w2 = '0;
    logic signed [15:0] exp_q [$];

    always #4 clk = ~clk;   // 125 MHz

    iir2_tdm uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .din       (din),
        .out_valid (out_valid),
        .dout      (dout)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Reference arithmetic (R7, R8)
    function automatic logic signed [15:0] clip16(input longint v);
        if (v > 32767) return 16'sd32767;
        if (v < -32768) return -16'sd32768;
        return 16'(v);
    endfunction

    function automatic logic signed [15:0] mulq(input int c, input logic signed [15:0] v);
        longint p;
        p = longint'(c) * longint'(v);
        p = (p + 2048) >>> 12;
        return clip16(p);
    endfunction

    function automatic logic signed [15:0] adds(input logic signed [15:0] a, input logic signed [15:0] b);
        return clip16(longint'(a) + longint'(b));
    endfunction

    // Difference equations (R2, R3)
    function automatic logic signed [15:0] step(input logic signed [15:0] x);
        logic signed [15:0] w, y;
        w = adds(adds(mulq(1229, m_w1), mulq(819, m_w2)), mulq(20480, x));
        y = adds(adds(mulq(1638, m_w1), mulq(2458, m_w2)), mulq(2867, w));
        m_w2 = m_w1;
        m_w1 = w;
        return y;
    endfunction

    // Output monitor: compares each result in order (R2/R3, R4)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            got++;
            last_valid_cyc = cyc;
            last_out = dout;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected result", int'(dout), 0);
            end else begin
                mon_exp = exp_q.pop_front();
                check(dout == mon_exp, "R2/R3 result value", int'(dout), int'(mon_exp));
            end
        end
    end

    task automatic send(input logic signed [15:0] x);
        @(negedge clk);
        start = 1'b1;
        din = x;
        sent_cyc = cyc;
        exp_q.push_back(step(x));
        @(negedge clk);
        start = 1'b0;
        din = 16'sh5A5A;
        repeat (4) @(negedge clk);
    endtask

    task automatic drain();
        repeat (16) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(dout == 16'sd0, "R1 dout in reset", int'(dout), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check(got == 0, "R1 no result before a sample", got, 0);
        check(dout == 16'sd0, "R1 dout after reset", int'(dout), 0);
    endtask

    task automatic t_latency();
        int g0;
        g0 = got;
        send(16'sd1200);
        drain();
        check(got - g0 == 1, "R4 one result per sample", got - g0, 1);
        check(last_valid_cyc - sent_cyc == 10, "R4 latency", last_valid_cyc - sent_cyc, 10);
    endtask

    task automatic t_impulse_gaps();
        int g0;
        g0 = got;
        send(16'sd800);
        repeat (9) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            send(16'sd0);
            repeat (k * 3 + 1) @(negedge clk);
        end
        drain();
        check(got - g0 == 7, "R9 results across idle gaps", got - g0, 7);
    endtask

    task automatic t_back_to_back();
        int g0;
        g0 = got;
        for (int k = 0; k < 12; k++) send(16'(k * 173 - 900));
        drain();
        check(got - g0 == 12, "R6 sustained one sample per 6 cycles", got - g0, 12);
    endtask

    task automatic t_alternating();
        int g0;
        g0 = got;
        for (int k = 0; k < 8; k++) send((k % 2 == 0) ? 16'sd2000 : -16'sd2001);
        drain();
        check(got - g0 == 8, "R8 alternating-sign stream count", got - g0, 8);
    endtask

    task automatic t_ignore_mid();
        int g0;
        g0 = got;
        @(negedge clk);
        start = 1'b1;
        din = 16'sd500;
        exp_q.push_back(step(16'sd500));
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            start = 1'b1;
            din = -16'sd7000;
        end
        @(negedge clk);
        start = 1'b0;
        din = '0;
        drain();
        check(got - g0 == 1, "R5 mid-period starts ignored", got - g0, 1);
        // following sample shows state was not disturbed (compared by monitor)
        send(16'sd100);
        drain();
        check(got - g0 == 2, "R5 state intact after ignored starts", got - g0, 2);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 20; k++) send(16'sd0);
        for (int k = 0; k < 3; k++) send(16'sd32000);
        drain();
        check(last_out == 16'sd32767, "R7 clip at top", int'(last_out), 32767);
        for (int k = 0; k < 4; k++) send(-16'sd32768);
        drain();
        check(last_out == -16'sd32768, "R7 clip at bottom", int'(last_out), -32768);
    endtask

    task automatic t_hold();
        logic signed [15:0] ref_v;
        send(16'sd321);
        drain();
        ref_v = last_out;
        for (int k = 0; k < 3; k++) begin
            repeat (5) @(negedge clk);
            check(dout == ref_v, "R10 dout held while idle", int'(dout), int'(ref_v));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_impulse_gaps();
        t_back_to_back();
        t_alternating();
        t_ignore_mid();
        t_saturate();
        t_hold();
        drain();
        check(exp_q.size() == 0, "R4 all samples produced results", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule